// File: doc/BRIEF.md
# Keyboard/Mouse Serial Frame Receiver

This block takes bytes that a keyboard or mouse sends toward the host over the two-wire open-collector serial link. Both line levels arrive asynchronously. Each passes through a two-stage synchronizer and a small persistence filter. The block then watches the filtered device clock for high-to-low transitions and takes one data bit at each one.

Eleven such bits form a frame. Bit 0 is a start bit that must be 0. Bits 1 to 8 carry the byte, least significant bit first. Bit 9 is a parity bit chosen so that the byte plus this bit hold an odd number of ones. Bit 10 is a stop bit that must be 1.

When the eleventh bit lands, the block presents the byte with a one-cycle valid strobe. Two flags come with it: one for a parity fault and one for a start or stop fault. The host logic can hold the bus inhibited through a request input, which makes the block pull the clock line low. Any partly received frame is then thrown away. A partial frame is also thrown away when the device clock stays silent longer than a programmable number of system cycles.

Top module: `kbd_frame_rx`

## Requirements
- R1: After reset, byte_o is 0, byte_valid_o is 0, both error flags are 0 and clk_pull_o is 0.
- R2: A frame whose start bit is 0, whose stop bit is 1 and whose parity is odd yields byte_o equal to the eight data bits, taking the first data bit after the start bit as bit 0. Both error flags are 0.
- R3: A frame whose data bits plus parity bit hold an even number of ones sets par_err_o with the strobe. byte_o still carries the data bits.
- R4: A frame with a start bit of 1 or a stop bit of 0 sets frm_err_o with the strobe.
- R5: byte_valid_o is high for exactly one system cycle per completed frame. byte_o and both flags change only in a cycle where byte_valid_o is high.
- R6: clk_pull_o goes high in the cycle after inhibit_i is high and goes low in the cycle after inhibit_i is low.
- R7: No strobe occurs in the cycle after a cycle with inhibit_i high. Bits received before an inhibit are discarded, so the next full frame after release is reported alone and correctly.
- R8: If a partial frame sees no device clock fall for TIMEOUT_CYC system cycles, it is discarded. The next full frame is reported alone and correctly.
- R9: A low pulse on the device clock that lasts fewer than FILT_LEN system cycles is not taken as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_clk_i | input | 1 | Device clock line level (asynchronous) |
| line_dat_i | input | 1 | Device data line level (asynchronous) |
| inhibit_i | input | 1 | Host request to hold the bus inhibited |
| clk_pull_o | output | 1 | Drive the clock line low when 1 |
| byte_o | output | 8 | Last received byte |
| byte_valid_o | output | 1 | One-cycle strobe for a completed frame |
| par_err_o | output | 1 | Parity fault of the last frame |
| frm_err_o | output | 1 | Start/stop fault of the last frame |

## Verification
A bit counter that is off by one shows up at the ports as a shifted byte or a false framing flag on the very next strobe. A counter that is not cleared after an inhibit or a silence shows up as a spurious or corrupted byte on the following frame. A filter that is too permissive lets a glitch insert an extra bit, which corrupts that same frame. Each of these faults is therefore visible within one frame of the disturbance.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
    localparam int FRAME_BITS = 11;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0]      nbit;
        logic [FRAME_BITS-1:0] shreg;
        logic                  clk_prev;
        logic [7:0]            data;
        logic                  valid;
        logic                  perr;
        logic                  ferr;
        logic                  pull;
    } core_st_t;
endpackage

// File: rtl/kbd_line_cond.sv
module kbd_line_cond #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int FC_W = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]      sync;
        logic            filt;
        logic [FC_W-1:0] cnt;
    } cond_st_t;

    cond_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], raw_i};
        if (st_q.sync[1] == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == FC_W'(FILT_LEN - 1)) begin
            st_d.filt = st_q.sync[1];
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: 2'b11, filt: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign clean_o = st_q.filt;
endmodule

// File: rtl/kbd_quiet_timer.sv
module kbd_quiet_timer #(
    parameter int TIMEOUT_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int QW = $clog2(TIMEOUT_CYC + 1);

    logic [QW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i || !run_i || expired_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = run_i && (cnt_q == QW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/kbd_frame_core.sv
module kbd_frame_core
    import kbd_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       sdat_i,
    input  logic       inhibit_i,
    input  logic       quiet_i,
    output logic       busy_o,
    output logic       fall_o,
    output logic       pull_o,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic       perr_o,
    output logic       ferr_o
);
    core_st_t st_q, st_d;
    logic [FRAME_BITS-1:0] frame_full;
    logic                  fall;

    assign fall       = st_q.clk_prev && !sclk_i;
    assign frame_full = {sdat_i, st_q.shreg[FRAME_BITS-1:1]};

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = sclk_i;
        st_d.valid    = 1'b0;
        st_d.pull     = inhibit_i;
        if (inhibit_i || quiet_i) begin
            st_d.nbit = '0;
        end else if (fall) begin
            st_d.shreg = frame_full;
            if (st_q.nbit == CNT_W'(FRAME_BITS - 1)) begin
                st_d.nbit  = '0;
                st_d.valid = 1'b1;
                st_d.data  = frame_full[8:1];
                st_d.perr  = ~(^frame_full[9:1]);
                st_d.ferr  = frame_full[0] | ~frame_full[10];
            end else begin
                st_d.nbit = st_q.nbit + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{nbit: '0, shreg: '0, clk_prev: 1'b1, data: '0,
                      valid: 1'b0, perr: 1'b0, ferr: 1'b0, pull: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.nbit != '0);
    assign fall_o  = fall;
    assign pull_o  = st_q.pull;
    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign perr_o  = st_q.perr;
    assign ferr_o  = st_q.ferr;
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
    parameter int FILT_LEN    = 4,
    parameter int TIMEOUT_CYC = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_clk_i,
    input  logic       line_dat_i,
    input  logic       inhibit_i,
    output logic       clk_pull_o,
    output logic [7:0] byte_o,
    output logic       byte_valid_o,
    output logic       par_err_o,
    output logic       frm_err_o
);
    logic [1:0] raw_lines, clean_lines;
    logic       busy, fall, quiet;

    assign raw_lines = {line_dat_i, line_clk_i};

    for (genvar g = 0; g < 2; g++) begin : g_cond
        kbd_line_cond #(.FILT_LEN(FILT_LEN)) u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[g]),
            .clean_o (clean_lines[g])
        );
    end

    kbd_quiet_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (fall),
        .run_i     (busy),
        .expired_o (quiet)
    );

    kbd_frame_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (clean_lines[0]),
        .sdat_i    (clean_lines[1]),
        .inhibit_i (inhibit_i),
        .quiet_i   (quiet),
        .busy_o    (busy),
        .fall_o    (fall),
        .pull_o    (clk_pull_o),
        .data_o    (byte_o),
        .valid_o   (byte_valid_o),
        .perr_o    (par_err_o),
        .ferr_o    (frm_err_o)
    );
endmodule

// File: rtl/kbd_frame_rx_chk.sv
module kbd_frame_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       inhibit_i,
    input logic       clk_pull_o,
    input logic [7:0] byte_o,
    input logic       byte_valid_o,
    input logic       par_err_o,
    input logic       frm_err_o
);
    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);
    // R5
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byte_o) |-> byte_valid_o);
    // R3
    perr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(par_err_o) |-> byte_valid_o);
    // R4
    ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frm_err_o) |-> byte_valid_o);
    // R6
    pull_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> clk_pull_o);
    // R6
    pull_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_i |=> !clk_pull_o);
    // R7
    no_strobe_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> !byte_valid_o);
endmodule

bind kbd_frame_rx kbd_frame_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inhibit_i    (inhibit_i),
    .clk_pull_o   (clk_pull_o),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .par_err_o    (par_err_o),
    .frm_err_o    (frm_err_o)
);

// File: tb/tb_kbd_frame_rx.sv
module tb_kbd_frame_rx;
    localparam int FILT = 3;
    localparam int TMO  = 400;
    localparam int HALF = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dev_clk = 1'b1, dev_dat = 1'b1, inhibit = 1'b0;
    logic clk_pull, bvalid, perr, ferr;
    logic [7:0] bval;
    logic line_clk;

    int checks = 0, fails = 0;
    logic [9:0] expq[$];

    always #2 clk = ~clk;
    assign line_clk = dev_clk & ~clk_pull;

    kbd_frame_rx #(.FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .line_clk_i(line_clk), .line_dat_i(dev_dat),
        .inhibit_i(inhibit), .clk_pull_o(clk_pull), .byte_o(bval),
        .byte_valid_o(bvalid), .par_err_o(perr), .frm_err_o(ferr));

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // send nbits of a frame; expectation pushed only for complete frames
    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_start,
                        input bit bad_stop, input int nbits, input bit glitch);
        logic [10:0] f;
        f[0]   = bad_start;
        f[8:1] = d;
        f[9]   = ~(^d) ^ bad_par;
        f[10]  = ~bad_stop;
        if (nbits == 11)
            expq.push_back({d, bad_par, bad_start | bad_stop});
        for (int i = 0; i < nbits; i++) begin
            dev_dat = f[i];
            wait_cyc(HALF);
            if (glitch && i == 4) begin
                dev_clk = 1'b0; wait_cyc(1); dev_clk = 1'b1; wait_cyc(HALF);
            end
            dev_clk = 1'b0;
            wait_cyc(HALF);
            dev_clk = 1'b1;
        end
        wait_cyc(HALF);
        dev_dat = 1'b1;
        wait_cyc(4 * HALF);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && bvalid) begin
            if (expq.size() == 0) begin
                check(0, "R7/R8 unexpected strobe", {24'd0, bval}, 0);
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                check(bval == e[9:2], "R2 byte", bval, e[9:2]);
                check(perr == e[1], "R3 parity flag", perr, e[1]);
                check(ferr == e[0], "R4 frame flag", ferr, e[0]);
            end
        end
    end

    // R5: strobe width
    always @(negedge clk) begin
        if (rst_n && bvalid) begin
            @(negedge clk);
            check(!bvalid, "R5 strobe width", bvalid, 0);
        end
    end

    initial begin
        fork
            begin
                wait_cyc(5);
                @(negedge clk);
                check(bval == 8'h00 && !bvalid && !perr && !ferr && !clk_pull,
                      "R1 reset state", {bval, bvalid, perr, ferr, clk_pull}, 0);
                rst_n = 1'b1;
                wait_cyc(10);
                send(8'h15, 0, 0, 0, 11, 0);          // R2
                send(8'hA5, 0, 0, 0, 11, 0);          // R2
                send(8'h00, 0, 0, 0, 11, 0);          // R2
                send(8'hFF, 0, 0, 0, 11, 0);          // R2
                send(8'h3C, 1, 0, 0, 11, 0);          // R3
                send(8'h81, 0, 1, 0, 11, 0);          // R4 start
                send(8'h7E, 0, 0, 1, 11, 0);          // R4 stop
                // R8: partial frame then silence
                send(8'h12, 0, 0, 0, 4, 0);
                wait_cyc(TMO + 200);
                send(8'h5A, 0, 0, 0, 11, 0);
                // R7: inhibit mid-frame
                send(8'hC3, 0, 0, 0, 5, 0);
                @(negedge clk); inhibit = 1'b1;
                wait_cyc(2); @(negedge clk);
                check(clk_pull, "R6 pull on", clk_pull, 1);
                dev_dat = 1'b0; wait_cyc(30); dev_dat = 1'b1;
                @(negedge clk); inhibit = 1'b0;
                wait_cyc(2); @(negedge clk);
                check(!clk_pull, "R6 pull off", clk_pull, 0);
                wait_cyc(40);
                send(8'h96, 0, 0, 0, 11, 0);
                // R9: short glitch ignored
                send(8'h4D, 0, 0, 0, 11, 1);
                wait_cyc(50);
                check(expq.size() == 0, "R2 all frames reported", expq.size(), 0);
            end
            begin
                wait_cyc(150000);
                check(0, "watchdog", 0, 1);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule